// File: doc/BRIEF.md
# Multi-Lane Receive Deskew Aligner

This block sits behind a set of independent receive lanes. Each lane delivers word-aligned 32-bit decoded words with one K-character flag per byte and a code-violation flag. Each lane is clocked by its own recovered clock, and these clocks have no fixed phase relation. Every lane writes into a small asynchronous FIFO. On a common read clock the block discards words on each grouped lane until an alignment marker sits at the FIFO head. Once every grouped lane shows its marker, the block releases all of them in the same read cycle. From then on it keeps them in lockstep and raises one frame pulse for the whole group each time the markers come out together.

The marker is either a comma character (K28.5 in byte 0) or the per-word code-violation indication, chosen by `marker_sel`. A lane mask picks which lanes form the group. Lanes outside the mask are drained and have no effect on the alignment decision. If the FIFOs or the decoder are bypassed, each lane's data, K flags and clock appear directly on the bypass outputs. In that case no alignment or frame pulse takes place.

If a grouped FIFO runs dry or overflows, the block raises a sticky error flag and goes back to searching for markers on all grouped lanes.

Top module: `deskew_aligner`

## Requirements
- R1: While `rd_rst_n` is low, `al_valid`, `frame_pulse`, `aligned` and `align_err` read 0 from the next read-clock edge on.
- R2: With `marker_sel` = 0, a lane word is a marker when byte 0 (bits 7:0) equals 8'hBC and K flag bit 0 is set. On a frame pulse every grouped output carries that byte with K bit 0 high.
- R3: With `marker_sel` = 1, a lane word is a marker when its `lane_cv` bit is high, whatever its data or K flags.
- R4: Grouped lanes with different arrival skews and clock phases come out with their marker words in the same `al_valid` cycle. The words that follow keep that lane-to-lane relationship, and `aligned` stays high.
- R5: `frame_pulse` is one read cycle wide. It is high exactly in those `al_valid` cycles where the grouped outputs carry their marker words.
- R6: Lanes whose `grp_mask` bit is 0 never hold back alignment. Their `al_data` and `al_k` slices read 0.
- R7: No word is released (`al_valid` stays 0) while any grouped lane has not yet presented a marker.
- R8: If a grouped FIFO is empty while aligned, `align_err` rises and `aligned` falls. The block then re-aligns on the next set of markers.
- R9: If a grouped lane writes into a full FIFO, `align_err` rises.
- R10: With `fifo_bypass` = 1, `byp_clk`, `byp_data` and `byp_k` of each lane follow that lane's clock, data and K flags, and `al_valid` and `frame_pulse` stay 0.
- R11: With `dec_bypass` = 1, no alignment happens and no frame pulse is produced. Clearing it lets alignment resume.
- R12: `align_err` stays high until `rd_rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lane_clk | input | NUM_LANES | Recovered clock of each lane |
| lane_rst_n | input | NUM_LANES | Synchronous active-low reset per lane clock domain |
| lane_valid | input | NUM_LANES | Lane word present this lane cycle |
| lane_data | input | NUM_LANES*32 | Decoded lane words, lane n at bits 32n+31:32n |
| lane_k | input | NUM_LANES*4 | K flag per byte, lane n at bits 4n+3:4n |
| lane_cv | input | NUM_LANES | Code-violation indication per lane word |
| rd_clk | input | 1 | Common read clock |
| rd_rst_n | input | 1 | Synchronous active-low reset of the read domain |
| grp_mask | input | NUM_LANES | Lanes taking part in the aligned group |
| marker_sel | input | 1 | 0: comma marker, 1: code-violation marker |
| fifo_bypass | input | 1 | Pass lanes straight to the bypass outputs |
| dec_bypass | input | 1 | Decoder bypassed: alignment and frame pulse disabled |
| al_data | output | NUM_LANES*32 | Aligned words, zero when not valid or lane not grouped |
| al_k | output | NUM_LANES*4 | Aligned K flags, same gating as al_data |
| al_valid | output | 1 | Aligned words present this read cycle |
| frame_pulse | output | 1 | One pulse per group marker release |
| aligned | output | 1 | Group is locked |
| align_err | output | 1 | Sticky underflow/overflow flag |
| byp_clk | output | NUM_LANES | Lane clock in bypass, else 0 |
| byp_data | output | NUM_LANES*32 | Lane data in bypass, else 0 |
| byp_k | output | NUM_LANES*4 | Lane K flags in bypass, else 0 |

## Verification
A read pointer that slips on one lane shows up at once as marker words landing on different cycles on different output slices. It also shows up as a frame pulse with only some lanes carrying a marker, within one marker period (16 words in the bench). A stuck or missed overflow/underflow event shows as `aligned` staying high after a lane has stopped, or `align_err` staying low. Both can be seen a few cycles after the lane's FIFO drains or fills. A wrong alignment state shows as `al_valid` appearing before every grouped lane has sent its marker, or never appearing after bypass is cleared.

// File: rtl/aln_pkg.sv
// Package: shared word type, controller states and marker test for the
// multi-lane deskew aligner. Assumes lanes carry 32-bit words with 4 K flags.
package aln_pkg;

    localparam int          WORD_W     = 32;
    localparam int          KFLAG_W    = 4;
    localparam logic [7:0]  COMMA_BYTE = 8'hBC;

    // One lane word as stored in a lane FIFO
    typedef struct packed {
        logic               cv;
        logic [KFLAG_W-1:0] k;
        logic [WORD_W-1:0]  data;
    } lane_word_t;

    typedef enum logic [0:0] {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } aln_state_t;

    // Marker test: comma in byte 0 with its K flag, or the code-violation bit
    function automatic logic is_marker(input lane_word_t w, input logic use_cv);
        if (use_cv) begin
            return w.cv;
        end
        return w.k[0] && (w.data[7:0] == COMMA_BYTE);
    endfunction

endpackage

// File: rtl/aln_sync.sv
// Two-flop synchronizer for a vector of independent bits or a gray code.
// Assumes the source changes at most one bit per source clock for gray use.
module aln_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    // Two-stage capture into the destination domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/aln_lane_fifo.sv
// Asynchronous lane FIFO: written on the lane clock, read on the common
// read clock, gray pointers crossing both ways. Writes into a full FIFO are
// dropped and reported to the read domain as a one-cycle overflow pulse.
// Assumes DEPTH is a power of two.
module aln_lane_fifo
    import aln_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic       wr_clk,
    input  logic       wr_rst_n,
    input  logic       wr_en,
    input  lane_word_t wr_word,
    input  logic       rd_clk,
    input  logic       rd_rst_n,
    input  logic       rd_pop,
    output lane_word_t rd_head,
    output logic       rd_empty,
    output logic [PW-1:0] rd_fill,
    output logic       rd_ovf
);

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    lane_word_t    mem [DEPTH];
    logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
    logic [PW-1:0] rgray_w, wgray_r, rbin_w, wbin_r;
    logic          full_w, ovf_tgl_q, ovf_tgl_r, ovf_seen_q;
    logic          do_pop;

    // ---------------- write domain ----------------
    aln_sync #(.W(PW)) u_rptr_sync (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray_q), .q(rgray_w)
    );

    assign rbin_w = to_bin(rgray_w);
    assign full_w = (wbin_q - rbin_w) == PW'(DEPTH);

    // Write pointer advance, or overflow toggle when full
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wbin_q    <= '0;
            wgray_q   <= '0;
            ovf_tgl_q <= 1'b0;
        end else if (wr_en) begin
            if (full_w) begin
                ovf_tgl_q <= ~ovf_tgl_q;
            end else begin
                wbin_q  <= wbin_q + 1'b1;
                wgray_q <= to_gray(wbin_q + 1'b1);
            end
        end
    end

    // Storage write
    always_ff @(posedge wr_clk) begin
        if (wr_en && !full_w) begin
            mem[wbin_q[AW-1:0]] <= wr_word;
        end
    end

    // ---------------- read domain ----------------
    aln_sync #(.W(PW)) u_wptr_sync (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray_q), .q(wgray_r)
    );

    aln_sync #(.W(1)) u_ovf_sync (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(ovf_tgl_q), .q(ovf_tgl_r)
    );

    assign wbin_r   = to_bin(wgray_r);
    assign rd_fill  = wbin_r - rbin_q;
    assign rd_empty = (rd_fill == '0);
    assign rd_head  = mem[rbin_q[AW-1:0]];
    assign do_pop   = rd_pop && !rd_empty;
    assign rd_ovf   = ovf_tgl_r ^ ovf_seen_q;

    // Read pointer advance on pop
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rbin_q  <= '0;
            rgray_q <= '0;
        end else if (do_pop) begin
            rbin_q  <= rbin_q + 1'b1;
            rgray_q <= to_gray(rbin_q + 1'b1);
        end
    end

    // Edge detect of the synchronized overflow toggle
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            ovf_seen_q <= 1'b0;
        end else begin
            ovf_seen_q <= ovf_tgl_r;
        end
    end

endmodule

// File: rtl/aln_ctrl.sv
// Group alignment controller in the read domain. In SEARCH it drops
// non-marker heads of grouped lanes and releases the group once every grouped
// head is a marker with START_FILL words buffered. In LOCKED it pops all
// grouped lanes each cycle; an empty or overflowing grouped lane sets the
// sticky error and returns to SEARCH. Ungrouped lanes are drained freely.
module aln_ctrl
    import aln_pkg::*;
#(
    parameter int NL         = 4,
    parameter int PW         = 6,
    parameter int START_FILL = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bypass,
    input  logic [NL-1:0] grp_mask,
    input  logic [NL-1:0] head_mark,
    input  logic [NL-1:0] empty,
    input  logic [NL-1:0] ovf,
    input  logic [PW-1:0] fill [NL],
    output logic [NL-1:0] pop,
    output logic          load,
    output logic          mark_all,
    output logic          locked,
    output logic          err
);

    aln_state_t    state_q, state_d;
    logic          set_err;
    logic [NL-1:0] ready;
    logic          all_ready, any_under, any_ovf;

    // Per-lane readiness for release
    always_comb begin
        for (int i = 0; i < NL; i++) begin
            ready[i] = !grp_mask[i] ||
                       (head_mark[i] && !empty[i] && (fill[i] >= PW'(START_FILL)));
        end
    end

    assign all_ready = (|grp_mask) && (&ready);
    assign any_under = |(grp_mask & empty);
    assign any_ovf   = |(grp_mask & ovf);
    assign mark_all  = &(~grp_mask | head_mark);

    // Pop selection and next state
    always_comb begin
        pop     = '0;
        load    = 1'b0;
        set_err = 1'b0;
        state_d = state_q;
        if (bypass) begin
            pop     = ~empty;
            state_d = ST_SEARCH;
        end else begin
            pop     = ~grp_mask & ~empty;
            set_err = any_ovf;
            case (state_q)
                ST_SEARCH: begin
                    if (all_ready && !any_ovf) begin
                        pop     = pop | grp_mask;
                        load    = 1'b1;
                        state_d = ST_LOCKED;
                    end else begin
                        pop = pop | (grp_mask & ~empty & ~head_mark);
                    end
                end
                ST_LOCKED: begin
                    if (any_ovf || any_under) begin
                        set_err = 1'b1;
                        state_d = ST_SEARCH;
                    end else begin
                        pop  = pop | grp_mask;
                        load = 1'b1;
                    end
                end
                default: state_d = ST_SEARCH;
            endcase
        end
    end

    // State and sticky error registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEARCH;
            err     <= 1'b0;
        end else begin
            state_q <= state_d;
            err     <= err | set_err;
        end
    end

    assign locked = (state_q == ST_LOCKED);

endmodule

// File: rtl/deskew_aligner.sv
// Top of the multi-lane receive deskew aligner: one asynchronous FIFO per
// lane, a shared alignment controller and registered aligned outputs on the
// read clock. Bypass outputs are a direct combinational path per lane.
// Assumes configuration inputs are static while the read side runs.
module deskew_aligner
    import aln_pkg::*;
#(
    parameter int NUM_LANES  = 4,
    parameter int DEPTH      = 32,
    parameter int START_FILL = 2
) (
    input  logic [NUM_LANES-1:0]         lane_clk,
    input  logic [NUM_LANES-1:0]         lane_rst_n,
    input  logic [NUM_LANES-1:0]         lane_valid,
    input  logic [NUM_LANES*WORD_W-1:0]  lane_data,
    input  logic [NUM_LANES*KFLAG_W-1:0] lane_k,
    input  logic [NUM_LANES-1:0]         lane_cv,
    input  logic                         rd_clk,
    input  logic                         rd_rst_n,
    input  logic [NUM_LANES-1:0]         grp_mask,
    input  logic                         marker_sel,
    input  logic                         fifo_bypass,
    input  logic                         dec_bypass,
    output logic [NUM_LANES*WORD_W-1:0]  al_data,
    output logic [NUM_LANES*KFLAG_W-1:0] al_k,
    output logic                         al_valid,
    output logic                         frame_pulse,
    output logic                         aligned,
    output logic                         align_err,
    output logic [NUM_LANES-1:0]         byp_clk,
    output logic [NUM_LANES*WORD_W-1:0]  byp_data,
    output logic [NUM_LANES*KFLAG_W-1:0] byp_k
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic                 bypass;
    lane_word_t           head [NUM_LANES];
    logic [PW-1:0]        fill [NUM_LANES];
    logic [NUM_LANES-1:0] empty, ovf, pop, head_mark;
    logic                 load, mark_all;

    assign bypass = fifo_bypass | dec_bypass;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        lane_word_t          wword;
        logic [WORD_W-1:0]   out_d_q;
        logic [KFLAG_W-1:0]  out_k_q;

        assign wword = {lane_cv[g], lane_k[g*KFLAG_W +: KFLAG_W],
                        lane_data[g*WORD_W +: WORD_W]};

        aln_lane_fifo #(.DEPTH(DEPTH)) u_fifo (
            .wr_clk   (lane_clk[g]),
            .wr_rst_n (lane_rst_n[g]),
            .wr_en    (lane_valid[g]),
            .wr_word  (wword),
            .rd_clk   (rd_clk),
            .rd_rst_n (rd_rst_n),
            .rd_pop   (pop[g]),
            .rd_head  (head[g]),
            .rd_empty (empty[g]),
            .rd_fill  (fill[g]),
            .rd_ovf   (ovf[g])
        );

        assign head_mark[g] = is_marker(head[g], marker_sel);

        // Aligned output slice, zero unless released and grouped
        always_ff @(posedge rd_clk) begin
            if (!rd_rst_n) begin
                out_d_q <= '0;
                out_k_q <= '0;
            end else if (load && grp_mask[g]) begin
                out_d_q <= head[g].data;
                out_k_q <= head[g].k;
            end else begin
                out_d_q <= '0;
                out_k_q <= '0;
            end
        end

        assign al_data[g*WORD_W +: WORD_W]   = out_d_q;
        assign al_k[g*KFLAG_W +: KFLAG_W]    = out_k_q;
        assign byp_clk[g]                    = bypass & lane_clk[g];
        assign byp_data[g*WORD_W +: WORD_W]  = bypass ? lane_data[g*WORD_W +: WORD_W] : '0;
        assign byp_k[g*KFLAG_W +: KFLAG_W]   = bypass ? lane_k[g*KFLAG_W +: KFLAG_W] : '0;
    end

    aln_ctrl #(.NL(NUM_LANES), .PW(PW), .START_FILL(START_FILL)) u_ctrl (
        .clk       (rd_clk),
        .rst_n     (rd_rst_n),
        .bypass    (bypass),
        .grp_mask  (grp_mask),
        .head_mark (head_mark),
        .empty     (empty),
        .ovf       (ovf),
        .fill      (fill),
        .pop       (pop),
        .load      (load),
        .mark_all  (mark_all),
        .locked    (aligned),
        .err       (align_err)
    );

    // Common valid and group frame pulse
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            al_valid    <= 1'b0;
            frame_pulse <= 1'b0;
        end else begin
            al_valid    <= load;
            frame_pulse <= load & mark_all;
        end
    end

endmodule

// File: rtl/aln_checker.sv
// Property checker for deskew_aligner, attached by bind. Watches only the
// read-domain ports.
module aln_checker (
    input logic rd_clk,
    input logic rd_rst_n,
    input logic fifo_bypass,
    input logic dec_bypass,
    input logic al_valid,
    input logic frame_pulse,
    input logic aligned,
    input logic align_err
);

    a_r1_reset_clears: assert property (@(posedge rd_clk)
        !rd_rst_n |=> (!al_valid && !frame_pulse && !aligned && !align_err));

    a_r5_pulse_in_valid: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        frame_pulse |-> al_valid);

    a_r4_valid_when_locked: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        al_valid |-> aligned);

    a_r8_err_unlocks: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $rose(align_err) |-> !aligned);

    a_r12_err_sticky: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        align_err |=> align_err);

    a_r10_bypass_quiet: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (fifo_bypass || dec_bypass) |=> (!al_valid && !frame_pulse));

endmodule

bind deskew_aligner aln_checker u_aln_checker (
    .rd_clk      (rd_clk),
    .rd_rst_n    (rd_rst_n),
    .fifo_bypass (fifo_bypass),
    .dec_bypass  (dec_bypass),
    .al_valid    (al_valid),
    .frame_pulse (frame_pulse),
    .aligned     (aligned),
    .align_err   (align_err)
);

// File: tb/test_deskew_aligner.sv
`timescale 1ns/1ps
module test_deskew_aligner;

    localparam int NL = 4;
    localparam int MP = 16;

    logic [NL-1:0]    lane_clk, lane_rst_n, lane_valid, lane_cv;
    logic [NL*32-1:0] lane_data, al_data, byp_data;
    logic [NL*4-1:0]  lane_k, al_k, byp_k;
    logic [NL-1:0]    byp_clk;
    logic             rd_clk, rd_rst_n, marker_sel, fifo_bypass, dec_bypass;
    logic [NL-1:0]    grp_mask;
    logic             al_valid, frame_pulse, aligned, align_err;

    logic lrst_n;
    bit   run_en [NL];
    int   skew_q [NL];
    bit   cv_mode;

    int n_chk, n_fail;
    bit done;
    bit mon_en;
    int n_valid, n_pulse, n_pbad, n_mis, n_seq, n_ung, n_cbad;

    deskew_aligner #(.NUM_LANES(NL)) i_deskew_aligner (
        .lane_clk(lane_clk), .lane_rst_n(lane_rst_n), .lane_valid(lane_valid),
        .lane_data(lane_data), .lane_k(lane_k), .lane_cv(lane_cv),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .grp_mask(grp_mask),
        .marker_sel(marker_sel), .fifo_bypass(fifo_bypass), .dec_bypass(dec_bypass),
        .al_data(al_data), .al_k(al_k), .al_valid(al_valid), .frame_pulse(frame_pulse),
        .aligned(aligned), .align_err(align_err),
        .byp_clk(byp_clk), .byp_data(byp_data), .byp_k(byp_k)
    );

    assign lane_rst_n = {NL{lrst_n}};
    assign marker_sel = cv_mode;

    initial begin
        rd_clk = 1'b0;
        forever #2 rd_clk = ~rd_clk;
    end

    // Per-lane clock with its own phase, and word generator with its own skew
    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic        lclk, v, cv;
        logic [31:0] d;
        logic [3:0]  k;

        initial begin
            lclk = 1'b0;
            #(0.5 + 0.8 * g);
            forever #2 lclk = ~lclk;
        end

        initial begin
            int cnt;
            int s;
            cnt = 0; d = '0; k = '0; cv = 1'b0; v = 1'b0;
            forever begin
                @(negedge lclk);
                if (!lrst_n) begin
                    cnt = 0; v = 1'b0;
                end else if (run_en[g]) begin
                    s = cnt - skew_q[g];
                    v = 1'b1;
                    if (s < 0) begin
                        d = {24'hFFFFFF, 8'h5A}; k = 4'h0; cv = 1'b0;
                    end else if (s % MP == 0) begin
                        d  = {s[23:0], cv_mode ? 8'h5A : 8'hBC};
                        k  = cv_mode ? 4'h0 : 4'h1;
                        cv = cv_mode;
                    end else begin
                        d = {s[23:0], 8'h5A}; k = 4'h0; cv = 1'b0;
                    end
                    cnt++;
                end else begin
                    v = 1'b0;
                end
            end
        end

        assign lane_clk[g]         = lclk;
        assign lane_valid[g]       = v;
        assign lane_cv[g]          = cv;
        assign lane_data[g*32+:32] = d;
        assign lane_k[g*4+:4]      = k;
    end

    // Output monitor: marker coincidence, sequence equality, pulse placement
    always @(negedge rd_clk) begin
        int  rs;
        bit  have, anym, allm, m;
        if (mon_en) begin
            if (frame_pulse) n_pulse++;
            if (frame_pulse && !al_valid) n_pbad++;
            if (al_valid) begin
                n_valid++;
                have = 0; anym = 0; allm = 1; rs = 0;
                for (int i = 0; i < NL; i++) begin
                    if (grp_mask[i]) begin
                        m = (al_data[i*32+8 +: 24] % MP) == 0;
                        anym = anym | m;
                        allm = allm & m;
                        if (have && al_data[i*32+8 +: 24] != rs[23:0]) n_seq++;
                        if (!have) begin rs = int'(al_data[i*32+8 +: 24]); have = 1; end
                        if (frame_pulse && !cv_mode &&
                            (al_data[i*32 +: 8] != 8'hBC || al_k[i*4] != 1'b1)) n_cbad++;
                        if (frame_pulse && cv_mode &&
                            (al_data[i*32 +: 8] != 8'h5A || al_k[i*4+:4] != 4'h0)) n_cbad++;
                    end else if (al_data[i*32 +: 32] != 0 || al_k[i*4 +: 4] != 0) begin
                        n_ung++;
                    end
                end
                if (anym != allm) n_mis++;
                if (allm != frame_pulse) n_pbad++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic mon_clear();
        n_valid = 0; n_pulse = 0; n_pbad = 0; n_mis = 0;
        n_seq = 0; n_ung = 0; n_cbad = 0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    task automatic set_skew(input int a, input int b, input int c, input int d);
        skew_q[0] = a; skew_q[1] = b; skew_q[2] = c; skew_q[3] = d;
    endtask

    // Hold reset, load configuration, release with all lanes running
    task automatic setup(input logic [NL-1:0] m, input bit cvm, input bit fb, input bit db);
        mon_en = 0;
        @(negedge rd_clk);
        lrst_n = 0; rd_rst_n = 0;
        for (int i = 0; i < NL; i++) run_en[i] = 1'b0;
        grp_mask = m; cv_mode = cvm; fifo_bypass = fb; dec_bypass = db;
        cycles(6);
        lrst_n = 1; rd_rst_n = 1;
        for (int i = 0; i < NL; i++) run_en[i] = 1'b1;
        mon_clear();
        mon_en = 1;
    endtask

    task automatic t_reset();
        mon_en = 0;
        @(negedge rd_clk);
        lrst_n = 0; rd_rst_n = 0;
        cycles(4);
        check(al_valid == 0,    "R1 al_valid",    al_valid, 0);
        check(frame_pulse == 0, "R1 frame_pulse", frame_pulse, 0);
        check(aligned == 0,     "R1 aligned",     aligned, 0);
        check(align_err == 0,   "R1 align_err",   align_err, 0);
    endtask

    task automatic t_deskew(input bit cvm, input string req);
        setup('1, cvm, 0, 0);
        cycles(400);
        check(aligned == 1,   {"R4 locked ", req}, aligned, 1);
        check(align_err == 0, {"R4 no error ", req}, align_err, 0);
        check(n_valid > 300,  {"R4 valid words ", req}, n_valid, 300);
        check(n_mis == 0,     {"R4 marker coincidence ", req}, n_mis, 0);
        check(n_seq == 0,     {"R4 lane words in step ", req}, n_seq, 0);
        check(n_pbad == 0,    {"R5 pulse placement ", req}, n_pbad, 0);
        check(n_pulse == (n_valid + MP - 1) / MP, {"R5 pulse count ", req},
              n_pulse, (n_valid + MP - 1) / MP);
        check(n_cbad == 0,    {req, " marker word at outputs"}, n_cbad, 0);
    endtask

    task automatic t_mask();
        set_skew(4, 0, 1, 0);
        setup(4'b0101, 0, 0, 0);
        run_en[1] = 0; run_en[3] = 0;
        cycles(400);
        check(aligned == 1,  "R6 group locks without lanes 1,3", aligned, 1);
        check(n_valid > 300, "R6 valid words", n_valid, 300);
        check(n_ung == 0,    "R6 ungrouped outputs zero", n_ung, 0);
        check(n_mis == 0 && n_seq == 0, "R6 grouped lanes aligned", n_mis + n_seq, 0);
    endtask

    task automatic t_missing();
        set_skew(0, 1, 2, 3);
        setup('1, 0, 0, 0);
        run_en[2] = 0;
        cycles(150);
        check(n_valid == 0,   "R7 nothing released", n_valid, 0);
        check(aligned == 0,   "R7 not locked", aligned, 0);
        check(align_err == 1, "R9 overflow flagged", align_err, 1);
    endtask

    task automatic t_underflow();
        set_skew(0, 0, 0, 0);
        setup('1, 0, 0, 0);
        cycles(100);
        check(aligned == 1 && align_err == 0, "R8 locked before stall", aligned, 1);
        mon_en = 0;
        run_en[1] = 0;
        cycles(12);
        check(align_err == 1, "R8 underflow flagged", align_err, 1);
        check(aligned == 0,   "R8 lock dropped", aligned, 0);
        run_en[1] = 1;
        cycles(80);
        mon_clear();
        mon_en = 1;
        cycles(200);
        check(aligned == 1,   "R8 re-locked", aligned, 1);
        check(n_mis == 0,     "R8 markers coincide after re-lock", n_mis, 0);
        check(n_pulse >= 10,  "R8 pulses after re-lock", n_pulse, 10);
        check(align_err == 1, "R12 error held", align_err, 1);
        mon_en = 0;
        @(negedge rd_clk);
        rd_rst_n = 0;
        cycles(2);
        check(align_err == 0, "R12 cleared by reset", align_err, 0);
    endtask

    task automatic t_bypass();
        set_skew(0, 2, 1, 3);
        setup('1, 0, 1, 0);
        cycles(60);
        check(n_valid == 0 && n_pulse == 0, "R10 aligned path quiet", n_valid + n_pulse, 0);
        @(posedge lane_clk[2]);
        #1;
        check(byp_clk[2] == 1'b1, "R10 bypass clock follows lane", byp_clk[2], 1);
        check(byp_data[64+:32] == lane_data[64+:32] && byp_k[8+:4] == lane_k[8+:4],
              "R10 bypass data follows lane", int'(byp_data[64+:32]), int'(lane_data[64+:32]));
        @(negedge lane_clk[0]);
        #0.5;
        check(byp_clk[0] == 1'b0 && byp_data[31:0] == lane_data[31:0],
              "R10 bypass lane 0", int'(byp_data[31:0]), int'(lane_data[31:0]));
        setup('1, 0, 0, 1);
        cycles(80);
        check(n_pulse == 0 && aligned == 0, "R11 no pulse in decoder bypass", n_pulse, 0);
        @(negedge rd_clk);
        dec_bypass = 0;
        cycles(120);
        check(aligned == 1 && n_pulse > 0, "R11 alignment resumes", aligned, 1);
    endtask

    initial begin
        n_chk = 0; n_fail = 0; done = 0; mon_en = 0;
        lrst_n = 0; rd_rst_n = 0; cv_mode = 0;
        grp_mask = '1; fifo_bypass = 0; dec_bypass = 0;
        for (int i = 0; i < NL; i++) begin run_en[i] = 1'b0; skew_q[i] = 0; end
        mon_clear();
        t_reset();
        set_skew(0, 3, 5, 1);
        t_deskew(0, "R2 comma");
        set_skew(2, 0, 4, 5);
        t_deskew(1, "R3 code violation");
        t_mask();
        t_missing();
        t_underflow();
        t_bypass();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge rd_clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule